// File: doc/BRIEF.md
# Indirect Calibration Register Access Port

This block gives a host access to a small internal calibration register space through four windows on a plain register bus. The host loads the window that holds a 6-bit internal address and a direction flag. For a write it also loads the window that holds the write data. It then raises the start flag. Each 0-to-1 transition of that flag launches exactly one internal transaction. A read places its value in a read-only result window, which keeps that value until the next read completes.

The internal space holds three registers. The unlock register at internal address 0x00 opens write protection when it receives a fixed key word, and any other value written there closes protection again. The manual calibration control register at 0x22 drives the manual-mode enable and the calibration code toward the delay line. The read-only code register at 0x26 returns the 5-bit calibration code that the delay line presents. While protection is closed, every write except one to the unlock register is dropped.

Top module: `calib_port_bridge`

## Requirements
- R1: After reset, protection is closed, `manual_en` and `manual_code` are 0, and all four windows read 0.
- R2: Window 0 (bus address 0) takes the internal address from bits [5:0] and the direction from bit 8, where 1 means read and 0 means write. All other written bits are dropped, so a read of window 0 returns only bits 8 and [5:0].
- R3: Window 1 bit 0 is the start flag and reads back. An internal transaction begins only on a 0-to-1 change of this flag. Writing 1 again while the flag is already 1 starts nothing.
- R4: Window 2 holds the 32-bit write data and reads back. Window 3 is the result and is read-only, so bus writes to it have no effect.
- R5: An internal write of 0xA500_0000 to address 0x00 opens protection. An internal write of any other value to 0x00 closes it.
- R6: While protection is closed, an internal write to any address other than 0x00 has no effect.
- R7: Internal address 0x22 holds the manual flag in bit 7 and the code in bits [4:0]. An unprotected write updates `manual_en`/`manual_code` in the cycle after the start edge. A write of 0 clears both. A read returns the flag in bit 7 and the code in bits [4:0], with all other bits 0.
- R8: A read of internal address 0x26 returns `cal_code_in` in bits [4:0] and 0 elsewhere. Writes to 0x26 have no effect.
- R9: The result window is updated one cycle after the start edge of a read and holds its value through internal writes until the next read.
- R10: Reads of address 0x00 and of unmapped addresses return 0. Writes to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Window write strobe |
| bus_addr | input | 2 | Window select: 0 control, 1 start, 2 write data, 3 result |
| bus_wdata | input | 32 | Window write data |
| bus_rdata | output | 32 | Read data of the selected window (combinational) |
| cal_code_in | input | 5 | Calibration code from the delay line |
| manual_en | output | 1 | Manual calibration mode enable |
| manual_code | output | 5 | Manual calibration code |

## Verification
The assertions assume that the host leaves the control and write-data windows unchanged during the cycle after a start edge. They also assume that `cal_code_in` is stable at the sampling edge. The bench meets both assumptions by loading those windows and the code input before it raises the start flag, and by touching only the start window until the transaction has finished. Random transactions draw addresses from the three mapped registers plus any 6-bit value, and about a quarter of the random write data is the unlock key. This makes the random stream alternate between protected and unprotected phases.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
    localparam int DW      = 32;
    localparam int IAW     = 6;
    localparam int CW      = 5;
    localparam int WAW     = 2;
    localparam int DIR_BIT = 8;
    localparam int MAN_BIT = 7;

    localparam logic [IAW-1:0] IA_KEY  = 6'h00;
    localparam logic [IAW-1:0] IA_MAN  = 6'h22;
    localparam logic [IAW-1:0] IA_CODE = 6'h26;
    localparam logic [DW-1:0]  KEY_WORD = 32'hA500_0000;

    typedef enum logic [WAW-1:0] {
        WIN_CTRL   = 2'd0,
        WIN_START  = 2'd1,
        WIN_WDATA  = 2'd2,
        WIN_RESULT = 2'd3
    } win_e;

    typedef struct packed {
        logic [IAW-1:0] addr;
        logic           rd;
        logic           start;
        logic           start_prev;
        logic [DW-1:0]  wdata;
    } win_t;

    typedef struct packed {
        logic           unlocked;
        logic           man_en;
        logic [CW-1:0]  man_code;
        logic [DW-1:0]  result;
    } spc_t;
endpackage

// File: rtl/cpb_window.sv
module cpb_window
    import cpb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [WAW-1:0] bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [DW-1:0]  result_in,
    output logic           acc_go,
    output logic           acc_rd,
    output logic [IAW-1:0] acc_addr,
    output logic [DW-1:0]  acc_wdata
);
    win_t win_d, win_q;

    always_comb begin
        win_d            = win_q;
        win_d.start_prev = win_q.start;
        if (bus_we) begin
            case (win_e'(bus_addr))
                WIN_CTRL: begin
                    win_d.addr = bus_wdata[IAW-1:0];
                    win_d.rd   = bus_wdata[DIR_BIT];
                end
                WIN_START: win_d.start = bus_wdata[0];
                WIN_WDATA: win_d.wdata = bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (win_e'(bus_addr))
            WIN_CTRL: begin
                bus_rdata[IAW-1:0] = win_q.addr;
                bus_rdata[DIR_BIT] = win_q.rd;
            end
            WIN_START:  bus_rdata[0] = win_q.start;
            WIN_WDATA:  bus_rdata    = win_q.wdata;
            default:    bus_rdata    = result_in;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign acc_go    = win_q.start & ~win_q.start_prev;
    assign acc_rd    = win_q.rd;
    assign acc_addr  = win_q.addr;
    assign acc_wdata = win_q.wdata;

    // R3
    single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |=> !acc_go);

    // R3
    launch_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |-> $past(bus_we) && ($past(bus_addr) == WIN_START) && $past(bus_wdata[0]));
endmodule

// File: rtl/cpb_space.sv
module cpb_space
    import cpb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_go,
    input  logic           acc_rd,
    input  logic [IAW-1:0] acc_addr,
    input  logic [DW-1:0]  acc_wdata,
    input  logic [CW-1:0]  cal_code_in,
    output logic           man_en,
    output logic [CW-1:0]  man_code,
    output logic [DW-1:0]  result
);
    spc_t spc_d, spc_q;
    logic [DW-1:0] rd_value;

    always_comb begin
        rd_value = '0;
        case (acc_addr)
            IA_MAN: begin
                rd_value[MAN_BIT] = spc_q.man_en;
                rd_value[CW-1:0]  = spc_q.man_code;
            end
            IA_CODE: rd_value[CW-1:0] = cal_code_in;
            default: rd_value = '0;
        endcase
    end

    always_comb begin
        spc_d = spc_q;
        if (acc_go) begin
            if (acc_rd) begin
                spc_d.result = rd_value;
            end else if (acc_addr == IA_KEY) begin
                spc_d.unlocked = (acc_wdata == KEY_WORD);
            end else if (spc_q.unlocked && acc_addr == IA_MAN) begin
                spc_d.man_en   = acc_wdata[MAN_BIT];
                spc_d.man_code = acc_wdata[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) spc_q <= '0;
        else        spc_q <= spc_d;
    end

    assign man_en   = spc_q.man_en;
    assign man_code = spc_q.man_code;
    assign result   = spc_q.result;

    // R5
    key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && !acc_rd && acc_addr == IA_KEY && acc_wdata == KEY_WORD) |=> spc_q.unlocked);

    // R6
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && !acc_rd && acc_addr != IA_KEY && !spc_q.unlocked)
        |=> ($stable(man_en) && $stable(man_code) && !spc_q.unlocked));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_go && acc_rd) |=> $stable(result));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && acc_rd && acc_addr != IA_MAN && acc_addr != IA_CODE) |=> (result == '0));

    // R8
    code_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && acc_rd && acc_addr == IA_CODE)
        |=> (result[CW-1:0] == $past(cal_code_in) && result[DW-1:CW] == '0));
endmodule

// File: rtl/calib_port_bridge.sv
module calib_port_bridge
    import cpb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [WAW-1:0] bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [CW-1:0]  cal_code_in,
    output logic           manual_en,
    output logic [CW-1:0]  manual_code
);
    logic           acc_go;
    logic           acc_rd;
    logic [IAW-1:0] acc_addr;
    logic [DW-1:0]  acc_wdata;
    logic [DW-1:0]  result;

    cpb_window u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .result_in (result),
        .acc_go    (acc_go),
        .acc_rd    (acc_rd),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata)
    );

    cpb_space u_space (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_go      (acc_go),
        .acc_rd      (acc_rd),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .cal_code_in (cal_code_in),
        .man_en      (manual_en),
        .man_code    (manual_code),
        .result      (result)
    );

    // R7
    manual_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_go |=> ($stable(manual_en) && $stable(manual_code)));
endmodule

// File: tb/calib_port_bridge_bench.sv
module calib_port_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  cal_code_in = '0;
    logic        manual_en;
    logic [4:0]  manual_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit         m_unl = 1'b0;
    bit         m_en = 1'b0;
    bit [4:0]   m_code = '0;
    bit [31:0]  m_res = '0;

    localparam logic [31:0] KEY = 32'hA500_0000;

    always #2 clk = ~clk;

    calib_port_bridge u_calib_port_bridge (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cal_code_in(cal_code_in),
        .manual_en(manual_en), .manual_code(manual_code)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bw(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic br(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] model_read(input logic [5:0] ia);
        logic [31:0] v = '0;
        if (ia == 6'h22) begin
            v[7] = m_en; v[4:0] = m_code;
        end else if (ia == 6'h26) begin
            v[4:0] = cal_code_in;
        end
        return v;
    endfunction

    task automatic model_access(input bit rd, input logic [5:0] ia, input logic [31:0] wd);
        if (rd) m_res = model_read(ia);
        else if (ia == 6'h00) m_unl = (wd == KEY);
        else if (m_unl && ia == 6'h22) begin
            m_en = wd[7]; m_code = wd[4:0];
        end
    endtask

    task automatic access(input bit rd, input logic [5:0] ia, input logic [31:0] wd);
        bw(2'd0, {23'd0, rd, 2'd0, ia});
        bw(2'd2, wd);
        bw(2'd1, 32'd1);
        bw(2'd1, 32'd0);
        model_access(rd, ia, wd);
    endtask

    task automatic check_state(input string tag);
        logic [31:0] r;
        chk({tag, " manual_en"}, {31'd0, manual_en}, {31'd0, m_en});
        chk({tag, " manual_code"}, {27'd0, manual_code}, {27'd0, m_code});
        br(2'd3, r);
        chk({tag, " result"}, r, m_res);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int w = 0; w < 4; w++) begin
            br(w[1:0], r);
            chk("R1 window after reset", r, 32'd0);
        end
        chk("R1 manual_en", {31'd0, manual_en}, 32'd0);

        // R2 control field masking
        bw(2'd0, 32'hFFFF_FFFF);
        br(2'd0, r);
        chk("R2 ctrl readback", r, 32'h0000_013F);

        // R4 write-data readback, result read-only
        bw(2'd2, 32'h1357_9BDF);
        br(2'd2, r);
        chk("R4 wdata readback", r, 32'h1357_9BDF);
        bw(2'd3, 32'hFFFF_FFFF);
        br(2'd3, r);
        chk("R4 result not writable", r, 32'd0);

        // R6 protected write dropped
        access(1'b0, 6'h22, 32'h0000_009F);
        check_state("R6 locked write");

        // R5 unlock then R7 manual write
        access(1'b0, 6'h00, KEY);
        access(1'b0, 6'h22, 32'hFFFF_FF8B);
        chk("R7 manual_en", {31'd0, manual_en}, 32'd1);
        chk("R7 manual_code", {27'd0, manual_code}, 32'h0B);
        access(1'b1, 6'h22, 32'd0);
        br(2'd3, r);
        chk("R7 readback of 0x22", r, 32'h0000_008B);

        // R3 start held high does not relaunch
        bw(2'd0, 32'h22);
        bw(2'd2, 32'h81);
        bw(2'd1, 32'd1);
        bw(2'd2, 32'h9E);
        bw(2'd1, 32'd1);
        br(2'd1, r);
        chk("R3 start readback", r, 32'd1);
        chk("R3 single launch code", {27'd0, manual_code}, 32'h01);
        bw(2'd1, 32'd0);
        m_en = 1'b1; m_code = 5'h01;

        // R8 code register read and write-ignore
        cal_code_in = 5'h15;
        access(1'b1, 6'h26, 32'd0);
        check_state("R8 code read");
        access(1'b0, 6'h26, 32'hFFFF_FFFF);
        access(1'b1, 6'h26, 32'd0);
        check_state("R8 code after write");

        // R9 result holds across writes
        access(1'b0, 6'h22, 32'h0000_0093);
        check_state("R9 hold across write");

        // R10 unmapped and key-address reads
        access(1'b1, 6'h3F, 32'd0);
        check_state("R10 unmapped read");
        access(1'b0, 6'h3F, 32'h0000_0000);
        check_state("R10 unmapped write");
        access(1'b1, 6'h00, 32'd0);
        check_state("R10 key address read");

        // R7 writing 0 disables
        access(1'b0, 6'h22, 32'd0);
        check_state("R7 zero disables");

        // R5 re-arm with wrong value
        access(1'b0, 6'h00, 32'h0000_1234);
        access(1'b0, 6'h22, 32'h0000_0088);
        check_state("R5 re-armed");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [5:0]  ia;
            logic [31:0] wd;
            bit          rd;
            case ($urandom % 4)
                0: ia = 6'h00;
                1: ia = 6'h22;
                2: ia = 6'h26;
                default: ia = 6'($urandom % 64);
            endcase
            wd = (($urandom % 4) == 0) ? KEY : $urandom;
            rd = ($urandom % 2) == 1;
            cal_code_in = 5'($urandom);
            access(rd, ia, wd);
            check_state("R7 R9 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule